// File: doc/BRIEF.md
# Calibration Coefficient Register Bank with Serial Access

This block keeps the offset (zero-scale) and gain (full-scale) correction coefficients for three input channel pairs. It also keeps a read-only register that holds the latest conversion result. All of these are reached through a bit-serial port. A command, already decoded from a command byte by a neighbouring block, supplies a 3-bit register-select code, a read flag and a channel index. The bank then moves one bit per `shift_en` cycle, most significant bit first, until the word is complete. It then falls back to waiting for the next command.

Coefficient writes pass through a staging shift register. A register changes only when all 24 bits have arrived, so a short or aborted write leaves it exactly as it was. A write aimed at the data register still consumes its full word length before the bank returns to idle, and those bits are dropped.

While a coefficient register is being read or written, the scaling datapath cannot use the coefficients. The bank raises `coef_access` during that time. It then flags the next conversion result it stores as suspect. Coefficient commands are refused during a calibration.

Top module: `cal_coef_bank`

The transfer controller has five states:
- IDLE: waiting for a command.
- DATA_RD: shifting out the data register.
- DATA_SINK: swallowing a write to the data register.
- COEF_RD: shifting out a coefficient.
- COEF_WR: shifting in a coefficient.

The transitions are:
- CMD_ACCEPT: IDLE to one of the other four states.
- WORD_DONE: any transfer state back to IDLE after the last bit.
- ABORT: any transfer state back to IDLE on `abort`.

## Requirements
- R1: After reset every zero-scale register reads 24'h1F4000 and every full-scale register reads 24'h5761AB, for all three channels.
- R2: In IDLE, `cmd_rs` code 3'b101 selects the data register, 3'b110 the zero-scale register and 3'b111 the full-scale register. `cmd_rd`=1 means read. Any other code leaves the bank idle, with `bit_out` and `coef_access` low.
- R3: A read presents the register MSB first. The first bit is on `bit_out` in the cycle after the command is accepted, and each `shift_en` cycle advances one bit.
- R4: A coefficient write updates the addressed register of the channel given by `chan_sel` at the clock edge of the 24th shifted bit. All other registers stay unchanged.
- R5: `abort` during a transfer returns the bank to IDLE and commits nothing.
- R6: `conv_valid` loads `conv_data` into the data register. A data read shifts out 24 bits when `word24`=1, or bits 23..8 (16 bits) when `word24`=0.
- R7: A data-register write consumes 16 or 24 bits, following `word24`, then returns to IDLE. The data register is unchanged.
- R8: A coefficient command is refused, and the bank stays in IDLE, while `cal_busy` is high or when `chan_sel` is 3 or more.
- R9: `coef_access` is high exactly while a coefficient read or write is in progress.
- R10: `result_suspect` goes to 1 when a conversion result is stored during or after a coefficient access. The next result stored with no access in between clears it to 0.
- R11: Commands are ignored while a transfer is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Decoded command present |
| cmd_rs | input | 3 | Register-select code |
| cmd_rd | input | 1 | 1 = read, 0 = write |
| chan_sel | input | 2 | Channel-pair index for coefficient access |
| word24 | input | 1 | Data register width: 1 = 24 bits, 0 = 16 bits |
| cal_busy | input | 1 | Calibration in progress |
| abort | input | 1 | Cancel the current transfer |
| shift_en | input | 1 | Move one bit this cycle |
| bit_in | input | 1 | Serial write data |
| bit_out | output | 1 | Serial read data, MSB first |
| conv_valid | input | 1 | New conversion result present |
| conv_data | input | 24 | Conversion result |
| coef_access | output | 1 | Coefficients are being accessed |
| result_suspect | output | 1 | Stored result may be wrongly scaled |

## Verification
A controller stuck outside IDLE shows at once: the next command is ignored, so the following read returns zeros on `bit_out` one cycle after that command. A wrong bit count shows within one word, because the read value comes back shifted or the next command is swallowed. A commit at the wrong time, or to the wrong slot, shows at the next read-back of that register, and of its neighbours in the table-driven sequence. A wrong access flag shows on `coef_access` in the first cycle after the command, and on `result_suspect` after the next one or two conversion loads.

// File: rtl/calbank_pkg.sv
package calbank_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DATA_RD,
        ST_DATA_SINK,
        ST_COEF_RD,
        ST_COEF_WR
    } xfer_state_t;

    localparam logic [2:0] RS_DATA = 3'b101;
    localparam logic [2:0] RS_ZERO = 3'b110;
    localparam logic [2:0] RS_GAIN = 3'b111;

    localparam int COEF_W  = 24;
    localparam int SHORT_W = 16;

    localparam logic [COEF_W-1:0] ZERO_RST = 24'h1F4000;
    localparam logic [COEF_W-1:0] GAIN_RST = 24'h5761AB;
endpackage

// File: rtl/calbank_store.sv
module calbank_store
    import calbank_pkg::*;
#(
    parameter int NCH = 3,
    parameter int CHW = 2,
    parameter int W   = COEF_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic           wr_fs,
    input  logic [CHW-1:0] wr_ch,
    input  logic [W-1:0]   wr_data,
    input  logic [CHW-1:0] rd_ch,
    output logic [W-1:0]   zs_rd,
    output logic [W-1:0]   fs_rd
);
    logic [W-1:0] zs_q [NCH];
    logic [W-1:0] fs_q [NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_pair
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                zs_q[g] <= W'(ZERO_RST);
                fs_q[g] <= W'(GAIN_RST);
            end else if (wr_en && wr_ch == CHW'(g)) begin
                if (wr_fs) fs_q[g] <= wr_data;
                else       zs_q[g] <= wr_data;
            end
        end
    end

    always_comb begin
        zs_rd = '0;
        fs_rd = '0;
        for (int i = 0; i < NCH; i++) begin
            if (rd_ch == CHW'(i)) begin
                zs_rd = zs_q[i];
                fs_rd = fs_q[i];
            end
        end
    end
endmodule

// File: rtl/calbank_result.sv
module calbank_result
    import calbank_pkg::*;
#(
    parameter int W = COEF_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         conv_valid,
    input  logic [W-1:0] conv_data,
    input  logic         coef_access,
    output logic [W-1:0] data_q,
    output logic         result_suspect
);
    logic dirty_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q         <= '0;
            result_suspect <= 1'b0;
            dirty_q        <= 1'b0;
        end else if (conv_valid) begin
            data_q         <= conv_data;
            result_suspect <= dirty_q | coef_access;
            dirty_q        <= coef_access;
        end else if (coef_access) begin
            dirty_q <= 1'b1;
        end
    end
endmodule

// File: rtl/calbank_xfer_ctrl.sv
module calbank_xfer_ctrl
    import calbank_pkg::*;
#(
    parameter int NCH = 3,
    parameter int CHW = 2,
    parameter int W   = COEF_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cmd_valid,
    input  logic [2:0]     cmd_rs,
    input  logic           cmd_rd,
    input  logic [CHW-1:0] chan_sel,
    input  logic           word24,
    input  logic           cal_busy,
    input  logic           abort,
    input  logic           shift_en,
    input  logic           bit_in,
    input  logic [W-1:0]   zs_rd,
    input  logic [W-1:0]   fs_rd,
    input  logic [W-1:0]   data_val,
    output logic           bit_out,
    output logic           coef_access,
    output logic           xfer_active,
    output logic           wr_en,
    output logic           wr_fs,
    output logic [CHW-1:0] wr_ch,
    output logic [W-1:0]   wr_data
);
    localparam int CW = $clog2(W + 1);
    localparam logic [CW-1:0] LEN_FULL  = CW'(W);
    localparam logic [CW-1:0] LEN_SHORT = CW'(SHORT_W);

    xfer_state_t    state_q, state_d;
    logic [W-1:0]   sh_q;
    logic [CW-1:0]  cnt_q, len_q;
    logic [CHW-1:0] ch_q;
    logic           fs_q;

    logic coef_cmd, ch_ok, last_bit;

    assign coef_cmd = (cmd_rs == RS_ZERO) || (cmd_rs == RS_GAIN);
    assign ch_ok    = int'(chan_sel) < NCH;
    assign last_bit = shift_en && (cnt_q == len_q - CW'(1));

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_valid) begin
                    if (cmd_rs == RS_DATA)
                        state_d = cmd_rd ? ST_DATA_RD : ST_DATA_SINK;
                    else if (coef_cmd && ch_ok && !cal_busy)
                        state_d = cmd_rd ? ST_COEF_RD : ST_COEF_WR;
                end
            end
            ST_DATA_RD, ST_DATA_SINK, ST_COEF_RD, ST_COEF_WR: begin
                if (abort || last_bit) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and shift path
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sh_q    <= '0;
            cnt_q   <= '0;
            len_q   <= LEN_FULL;
            ch_q    <= '0;
            fs_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE) begin
                cnt_q <= '0;
                if (cmd_valid) begin
                    len_q <= (cmd_rs == RS_DATA && !word24) ? LEN_SHORT : LEN_FULL;
                    ch_q  <= chan_sel;
                    fs_q  <= cmd_rs[0];
                    sh_q  <= (cmd_rs == RS_DATA) ? data_val :
                             (cmd_rs[0] ? fs_rd : zs_rd);
                end
            end else if (shift_en && !abort) begin
                sh_q  <= {sh_q[W-2:0], bit_in};
                cnt_q <= cnt_q + CW'(1);
            end
        end
    end

    // outputs
    always_comb begin
        bit_out     = 1'b0;
        coef_access = 1'b0;
        wr_en       = 1'b0;
        unique case (state_q)
            ST_IDLE:      ;
            ST_DATA_RD:   bit_out = sh_q[W-1];
            ST_DATA_SINK: ;
            ST_COEF_RD: begin
                bit_out     = sh_q[W-1];
                coef_access = 1'b1;
            end
            ST_COEF_WR: begin
                coef_access = 1'b1;
                wr_en       = last_bit && !abort;
            end
            default: ;
        endcase
    end

    assign xfer_active = (state_q != ST_IDLE);
    assign wr_fs       = fs_q;
    assign wr_ch       = ch_q;
    assign wr_data     = {sh_q[W-2:0], bit_in};
endmodule

// File: rtl/cal_coef_bank.sv
module cal_coef_bank
    import calbank_pkg::*;
#(
    parameter int NCH = 3,
    parameter int CHW = 2,
    parameter int W   = COEF_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cmd_valid,
    input  logic [2:0]     cmd_rs,
    input  logic           cmd_rd,
    input  logic [CHW-1:0] chan_sel,
    input  logic           word24,
    input  logic           cal_busy,
    input  logic           abort,
    input  logic           shift_en,
    input  logic           bit_in,
    output logic           bit_out,
    input  logic           conv_valid,
    input  logic [W-1:0]   conv_data,
    output logic           coef_access,
    output logic           result_suspect
);
    logic           xfer_active;
    logic           wr_en, wr_fs;
    logic [CHW-1:0] wr_ch;
    logic [W-1:0]   wr_data, zs_rd, fs_rd, data_q;

    calbank_xfer_ctrl #(.NCH(NCH), .CHW(CHW), .W(W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_rs(cmd_rs), .cmd_rd(cmd_rd),
        .chan_sel(chan_sel), .word24(word24), .cal_busy(cal_busy),
        .abort(abort), .shift_en(shift_en), .bit_in(bit_in),
        .zs_rd(zs_rd), .fs_rd(fs_rd), .data_val(data_q),
        .bit_out(bit_out), .coef_access(coef_access), .xfer_active(xfer_active),
        .wr_en(wr_en), .wr_fs(wr_fs), .wr_ch(wr_ch), .wr_data(wr_data)
    );

    calbank_store #(.NCH(NCH), .CHW(CHW), .W(W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_fs(wr_fs), .wr_ch(wr_ch), .wr_data(wr_data),
        .rd_ch(chan_sel), .zs_rd(zs_rd), .fs_rd(fs_rd)
    );

    calbank_result #(.W(W)) u_result (
        .clk(clk), .rst_n(rst_n),
        .conv_valid(conv_valid), .conv_data(conv_data),
        .coef_access(coef_access),
        .data_q(data_q), .result_suspect(result_suspect)
    );
endmodule

// File: rtl/calbank_checker.sv
module calbank_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic [2:0] cmd_rs,
    input logic       cal_busy,
    input logic       abort,
    input logic       shift_en,
    input logic       conv_valid,
    input logic       coef_access,
    input logic       xfer_active,
    input logic       result_suspect
);
    // R9: access window opens only from an accepted coefficient command
    assert_access_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(coef_access) |-> $past(cmd_valid && !cal_busy && cmd_rs[2:1] == 2'b11));

    // R5: abort ends any transfer on the next edge
    assert_abort_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_active && abort) |=> !xfer_active);

    // R11: a command arriving mid-transfer does not end or restart it
    assert_cmd_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_active && cmd_valid && !abort && !shift_en) |=> xfer_active);

    // R2: data-register code starts a transfer that is not a coefficient access
    assert_data_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer_active && cmd_valid && cmd_rs == 3'b101) |=> (xfer_active && !coef_access));

    // R10: result stored during access is flagged
    assert_suspect_mark_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_valid && coef_access) |=> result_suspect);
endmodule

bind cal_coef_bank calbank_checker u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_rs(cmd_rs),
    .cal_busy(cal_busy), .abort(abort), .shift_en(shift_en),
    .conv_valid(conv_valid), .coef_access(coef_access),
    .xfer_active(xfer_active), .result_suspect(result_suspect)
);

// File: tb/cal_coef_bank_test.sv
`timescale 1ns/1ps
module cal_coef_bank_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 0, cmd_rd = 0, word24 = 1, cal_busy = 0, abort = 0;
    logic shift_en = 0, bit_in = 0, conv_valid = 0;
    logic [2:0]  cmd_rs = 3'b000;
    logic [1:0]  chan_sel = 2'd0;
    logic [23:0] conv_data = '0;
    logic bit_out, coef_access, result_suspect;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    cal_coef_bank uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_rs(cmd_rs),
        .cmd_rd(cmd_rd), .chan_sel(chan_sel), .word24(word24),
        .cal_busy(cal_busy), .abort(abort), .shift_en(shift_en),
        .bit_in(bit_in), .bit_out(bit_out), .conv_valid(conv_valid),
        .conv_data(conv_data), .coef_access(coef_access),
        .result_suspect(result_suspect)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_bad++;
            $display("FAIL watchdog: act=%0d cycles exp=<100000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] rs, input logic rd, input logic [1:0] ch);
        @(negedge clk);
        cmd_valid = 1; cmd_rs = rs; cmd_rd = rd; chan_sel = ch;
        @(negedge clk);
        cmd_valid = 0;
    endtask

    // shift n bits; capture bit_out before each shift
    task automatic shift_bits(input int n, input logic [23:0] wdata, output logic [23:0] rdata);
        rdata = '0;
        for (int i = 0; i < n; i++) begin
            rdata    = {rdata[22:0], bit_out};
            bit_in   = wdata[n-1-i];
            shift_en = 1;
            @(negedge clk);
        end
        shift_en = 0;
    endtask

    task automatic conv(input logic [23:0] d);
        @(negedge clk);
        conv_valid = 1; conv_data = d;
        @(negedge clk);
        conv_valid = 0;
    endtask

    // {rd, rs[2:0], ch[1:0], 2'b00, data[23:0]}
    localparam int NV = 9;
    localparam logic [31:0] VEC [NV] = '{
        {1'b0, 3'b110, 2'd0, 2'b00, 24'hABCDEF},
        {1'b0, 3'b111, 2'd2, 2'b00, 24'h00F00D},
        {1'b0, 3'b110, 2'd2, 2'b00, 24'h800001},
        {1'b1, 3'b110, 2'd0, 2'b00, 24'hABCDEF},
        {1'b1, 3'b111, 2'd2, 2'b00, 24'h00F00D},
        {1'b1, 3'b110, 2'd2, 2'b00, 24'h800001},
        {1'b1, 3'b110, 2'd1, 2'b00, 24'h1F4000},
        {1'b1, 3'b111, 2'd0, 2'b00, 24'h5761AB},
        {1'b1, 3'b111, 2'd1, 2'b00, 24'h5761AB}
    };

    initial begin
        logic [23:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1/R9/R10 reset state at the ports
        chk("R9 reset access", {23'd0, coef_access}, 24'd0);
        chk("R10 reset suspect", {23'd0, result_suspect}, 24'd0);
        chk("R2 idle bit_out", {23'd0, bit_out}, 24'd0);

        // R6: load and read 24-bit data; R10 no access yet
        conv(24'h123456);
        chk("R10 clean result", {23'd0, result_suspect}, 24'd0);
        issue(3'b101, 1, 0);
        chk("R9 data read no access", {23'd0, coef_access}, 24'd0);
        shift_bits(24, 0, r);
        chk("R6 data read 24", r, 24'h123456);

        // R1 reset values on channel 0 before any write
        issue(3'b110, 1, 0); shift_bits(24, 0, r);
        chk("R1 zs ch0 reset", r, 24'h1F4000);

        // R3/R4/R1 table walk
        for (int i = 0; i < NV; i++) begin
            issue(VEC[i][30:28], VEC[i][31], VEC[i][27:26]);
            if (!VEC[i][31]) shift_bits(24, VEC[i][23:0], r);
            else begin
                shift_bits(24, 0, r);
                chk($sformatf("R3 R4 R1 vector %0d", i), r, VEC[i][23:0]);
            end
        end

        // R9 access window
        issue(3'b111, 1, 2);
        chk("R9 access during read", {23'd0, coef_access}, 24'd1);
        shift_bits(24, 0, r);
        chk("R9 access after read", {23'd0, coef_access}, 24'd0);

        // R10 suspect marking and clearing
        conv(24'hA5A5A5);
        chk("R10 suspect after access", {23'd0, result_suspect}, 24'd1);
        conv(24'h5AC3F0);
        chk("R10 suspect cleared", {23'd0, result_suspect}, 24'd0);

        // R6 16-bit read
        word24 = 0;
        issue(3'b101, 1, 0); shift_bits(16, 0, r);
        chk("R6 data read 16", r, 24'h005AC3);

        // R7 data write discarded, 16 and 24 bit lengths
        issue(3'b101, 0, 0); shift_bits(16, 24'h00FFFF, r);
        issue(3'b101, 1, 0); shift_bits(16, 0, r);
        chk("R7 sink 16 then idle", r, 24'h005AC3);
        word24 = 1;
        issue(3'b101, 0, 0); shift_bits(24, 24'hFFFFFF, r);
        issue(3'b101, 1, 0); shift_bits(24, 0, r);
        chk("R7 sink 24 then idle", r, 24'h5AC3F0);

        // R8 refused while calibrating
        cal_busy = 1;
        issue(3'b110, 0, 1);
        chk("R8 refused no access", {23'd0, coef_access}, 24'd0);
        shift_bits(24, 24'h123456, r);
        cal_busy = 0;
        issue(3'b110, 1, 1); shift_bits(24, 0, r);
        chk("R8 zs ch1 unchanged", r, 24'h1F4000);
        // R8 channel index 3 refused
        issue(3'b111, 1, 3);
        chk("R8 bad channel no access", {23'd0, coef_access}, 24'd0);

        // R5 abort mid-write
        issue(3'b111, 0, 1); shift_bits(10, 24'h000000, r);
        @(negedge clk); abort = 1; @(negedge clk); abort = 0;
        chk("R5 abort idle", {23'd0, coef_access}, 24'd0);
        issue(3'b111, 1, 1); shift_bits(24, 0, r);
        chk("R5 fs ch1 unchanged", r, 24'h5761AB);

        // R11 command mid-read ignored
        issue(3'b110, 1, 0); shift_bits(8, 0, r);
        begin
            logic [23:0] tail;
            @(negedge clk);
            cmd_valid = 1; cmd_rs = 3'b101; cmd_rd = 1;
            @(negedge clk);
            cmd_valid = 0;
            shift_bits(16, 0, tail);
            chk("R11 ignored command", {r[7:0], tail[15:0]}, 24'hABCDEF);
        end

        // R2 unused code stays idle
        issue(3'b011, 1, 0);
        chk("R2 unused code access", {23'd0, coef_access}, 24'd0);
        chk("R2 unused code bit_out", {23'd0, bit_out}, 24'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule